// File: doc/BRIEF.md
# Priority Pin Crossbar

This block connects a fixed set of on-chip digital functions to a bank of general-purpose pins. Software chooses which functions take part and which pins to reserve. The block then packs every signal of the enabled functions onto the free pins. The order is fixed: function priority first, then signal order within each function. The packing is filled from pin 0 upward. Pins that no function claims stay general-purpose I/O and are driven from the port latch. Each pin can use either a push-pull driver or an open-drain driver.

The mapping is purely combinational, so any change to the enables, the PCA width or the skip mask re-maps the pins in the same cycle. Enabling a function, or skipping a pin, moves every lower-priority signal to a new pin. Firmware has to account for this when it plans a pin layout. A function is connected only if all of its signals fit. When it does not fit, it is left out together with every function below it, and the overflow output is raised.

The signal vectors `periph_out`, `periph_oe` and `periph_in` use one fixed index per signal:

| Function | Bits |
|---|---|
| UART | 0-1 |
| SPI | 2-5 |
| two-wire serial bus | 6-7 |
| comparator 0 | 8-9 |
| comparator 1 | 10-11 |
| clock output | 12 |
| PCA | 13-19 |
| timers and external interrupts | 20-23 |
| LIN | 24-25 |

The enable bits in `func_en` follow this same order, from bit 0 (UART) up to bit 8 (LIN).

Top module: `pin_xbar`

## Requirements
- R1: The signals of the enabled functions take the non-skipped pins in ascending pin order, starting at pin 0. The signals are taken in ascending signal index, so a lower signal index always sits on a lower pin.
- R2: Function priority and pin counts follow the index table above. When enabled, UART takes 2 pins, SPI 4, the two-wire bus 2, each comparator 2, the clock output 1, the timer group 4 and LIN 2.
- R3: When enabled, PCA claims `pca_width` pins (0 to 7). These are its signals 13 through 13+`pca_width`-1.
- R4: A pin whose `pin_skip` bit is 1 is never claimed. Packing continues at the next pin, and the skipped pin behaves as general-purpose I/O.
- R5: `overflow` is 1 exactly when the enabled signals outnumber the non-skipped pins. The first function that does not fit completely is left unconnected, and so is every function below it.
- R6: A claimed pin takes its value from `periph_out` and its output enable from `periph_oe` for the claiming signal.
- R7: An unclaimed pin takes its value from `latch_out`, with its output enable requested.
- R8: When `pin_push_pull` is 0, the pin uses open-drain drive. `pad_out` is 0, and `pad_oe` is 1 only when the requested value is 0 and its output enable is requested.
- R9: `latch_rd` always equals `pad_in`, whatever the mapping.
- R10: For a connected signal, `periph_in` returns the pad input of its pin. For a signal with no pin, it returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_en | input | 9 | Function enables, bit 0 = UART up to bit 8 = LIN |
| pca_width | input | 3 | Number of PCA signals to route |
| pin_skip | input | NPIN | 1 = pin reserved, passed over by the crossbar |
| periph_out | input | 26 | Output value of each function signal |
| periph_oe | input | 26 | Output enable of each function signal |
| periph_in | output | 26 | Pad input returned to each function signal |
| latch_out | input | NPIN | Port latch value per pin |
| pin_push_pull | input | NPIN | 1 = push-pull, 0 = open-drain |
| pad_in | input | NPIN | Sensed pad level |
| pad_out | output | NPIN | Pad drive value |
| pad_oe | output | NPIN | Pad driver enable |
| latch_rd | output | NPIN | Latch readback of pad level |
| overflow | output | 1 | Enabled signals exceed free pins |

## Verification
The immediate assertions watch four things on every evaluation. A skipped pin always shows the latch drive. An open-drain pin never drives high. Connected signals appear in ascending pin order. The overflow output agrees with whether every active signal found a pin. Whether signals land on exactly the right pins, whether the PCA width is honoured, and whether functions are dropped whole at the cut-off are checked only by the bench. It compares each scenario against an independent packing model, using directed edge layouts and seeded random configurations.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int NFUNC   = 9;
    localparam int NSIG    = 26;
    localparam int MAXPIN  = 31;
    localparam int CW      = $clog2(MAXPIN + 1);
    localparam int PCA_MAX = 7;

    typedef enum logic [3:0] {
        F_UART   = 4'd0,
        F_SPI    = 4'd1,
        F_TWB    = 4'd2,
        F_CMP0   = 4'd3,
        F_CMP1   = 4'd4,
        F_CLKO   = 4'd5,
        F_PCA    = 4'd6,
        F_TMR    = 4'd7,
        F_LIN    = 4'd8
    } func_e;

    // Route descriptor: valid flag and an index (pin or signal)
    typedef struct packed {
        logic          valid;
        logic [CW-1:0] idx;
    } link_t;

    // Maximum number of signals owned by each function
    function automatic int func_width(input int f);
        case (f)
            0: return 2;
            1: return 4;
            2: return 2;
            3: return 2;
            4: return 2;
            5: return 1;
            6: return PCA_MAX;
            7: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic int func_base(input int f);
        int b;
        b = 0;
        for (int i = 0; i < NFUNC; i++) begin
            if (i < f) b += func_width(i);
        end
        return b;
    endfunction

    function automatic int sig_func(input int s);
        int f;
        f = 0;
        for (int i = 0; i < NFUNC; i++) begin
            if (s >= func_base(i)) f = i;
        end
        return f;
    endfunction

endpackage

// File: rtl/xbar_rank.sv
module xbar_rank
    import xbar_pkg::*;
#(
    parameter int NPIN = 25
) (
    input  logic [NFUNC-1:0] func_en,
    input  logic [2:0]       pca_width,
    input  logic [NPIN-1:0]  pin_skip,
    output logic [NSIG-1:0]  active,
    output logic [NSIG-1:0]  conn,
    output logic [CW-1:0]    ord [NSIG],
    output logic             overflow
);

    logic [CW-1:0]   nfree;
    logic [NFUNC-1:0] fits;

    always_comb begin
        nfree = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (!pin_skip[p]) nfree = nfree + 1'b1;
        end
    end

    // Ordinal of each active signal within the packed stream
    always_comb begin
        logic [CW-1:0] cnt;
        cnt = '0;
        for (int s = 0; s < NSIG; s++) begin
            int f;
            logic act;
            f   = sig_func(s);
            act = func_en[f];
            if (f == int'(F_PCA)) begin
                act = act && ((s - func_base(f)) < int'(pca_width));
            end
            active[s] = act;
            ord[s]    = cnt;
            if (act) cnt = cnt + 1'b1;
        end
        overflow = (cnt > nfree);
    end

    // A function fits only if its last active signal still has a pin
    always_comb begin
        for (int f = 0; f < NFUNC; f++) begin
            int endcnt;
            endcnt = 0;
            for (int s = 0; s < NSIG; s++) begin
                if (active[s] && sig_func(s) <= f) endcnt++;
            end
            fits[f] = (endcnt <= int'(nfree));
        end
    end

    always_comb begin
        for (int s = 0; s < NSIG; s++) begin
            conn[s] = active[s] && fits[sig_func(s)];
        end
    end

endmodule

// File: rtl/xbar_route.sv
module xbar_route
    import xbar_pkg::*;
#(
    parameter int NPIN = 25
) (
    input  logic [NPIN-1:0] pin_skip,
    input  logic [NSIG-1:0] conn,
    input  logic [CW-1:0]   ord [NSIG],
    output link_t           pin_link [NPIN],
    output link_t           sig_link [NSIG]
);

    logic [CW-1:0] frank [NPIN];

    // Rank of each pin among the free pins
    always_comb begin
        logic [CW-1:0] r;
        r = '0;
        for (int p = 0; p < NPIN; p++) begin
            frank[p] = r;
            if (!pin_skip[p]) r = r + 1'b1;
        end
    end

    always_comb begin
        for (int p = 0; p < NPIN; p++) begin
            pin_link[p] = '0;
            if (!pin_skip[p]) begin
                for (int s = 0; s < NSIG; s++) begin
                    if (conn[s] && ord[s] == frank[p]) begin
                        pin_link[p].valid = 1'b1;
                        pin_link[p].idx   = CW'(s);
                    end
                end
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NSIG; s++) begin
            sig_link[s] = '0;
            for (int p = 0; p < NPIN; p++) begin
                if (pin_link[p].valid && int'(pin_link[p].idx) == s) begin
                    sig_link[s].valid = 1'b1;
                    sig_link[s].idx   = CW'(p);
                end
            end
        end
    end

endmodule

// File: rtl/xbar_pad.sv
module xbar_pad (
    input  logic req_val,
    input  logic req_oe,
    input  logic push_pull,
    output logic pad_out,
    output logic pad_oe
);

    always_comb begin
        pad_out = push_pull ? req_val : 1'b0;
        pad_oe  = req_oe && (push_pull || !req_val);
    end

    always_comb begin
        if (!push_pull) begin
            AST_OD_NO_HIGH: assert (!(pad_oe && pad_out)) else $error("open-drain drove high"); // R8
        end
    end

endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
    import xbar_pkg::*;
#(
    parameter int NPIN = 25
) (
    input  logic [NFUNC-1:0] func_en,
    input  logic [2:0]       pca_width,
    input  logic [NPIN-1:0]  pin_skip,
    input  logic [NSIG-1:0]  periph_out,
    input  logic [NSIG-1:0]  periph_oe,
    output logic [NSIG-1:0]  periph_in,
    input  logic [NPIN-1:0]  latch_out,
    input  logic [NPIN-1:0]  pin_push_pull,
    input  logic [NPIN-1:0]  pad_in,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe,
    output logic [NPIN-1:0]  latch_rd,
    output logic             overflow
);

    logic [NSIG-1:0] active;
    logic [NSIG-1:0] conn;
    logic [CW-1:0]   ord [NSIG];
    link_t           pin_link [NPIN];
    link_t           sig_link [NSIG];
    logic [NPIN-1:0] req_val;
    logic [NPIN-1:0] req_oe;

    xbar_rank #(.NPIN(NPIN)) u_rank (
        .func_en  (func_en),
        .pca_width(pca_width),
        .pin_skip (pin_skip),
        .active   (active),
        .conn     (conn),
        .ord      (ord),
        .overflow (overflow)
    );

    xbar_route #(.NPIN(NPIN)) u_route (
        .pin_skip(pin_skip),
        .conn    (conn),
        .ord     (ord),
        .pin_link(pin_link),
        .sig_link(sig_link)
    );

    // Per-pin source select: claiming signal or port latch
    always_comb begin
        for (int p = 0; p < NPIN; p++) begin
            req_val[p] = latch_out[p];
            req_oe[p]  = 1'b1;
            for (int s = 0; s < NSIG; s++) begin
                if (pin_link[p].valid && int'(pin_link[p].idx) == s) begin
                    req_val[p] = periph_out[s];
                    req_oe[p]  = periph_oe[s];
                end
            end
        end
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pad
        xbar_pad u_pad (
            .req_val  (req_val[g]),
            .req_oe   (req_oe[g]),
            .push_pull(pin_push_pull[g]),
            .pad_out  (pad_out[g]),
            .pad_oe   (pad_oe[g])
        );
    end

    // Input return path
    always_comb begin
        for (int s = 0; s < NSIG; s++) begin
            periph_in[s] = 1'b1;
            for (int p = 0; p < NPIN; p++) begin
                if (sig_link[s].valid && int'(sig_link[s].idx) == p) periph_in[s] = pad_in[p];
            end
        end
    end

    assign latch_rd = pad_in;

    // Checks across rank, route and pad logic
    always_comb begin
        int nlinked;
        int last;
        nlinked = 0;
        last    = -1;
        for (int s = 0; s < NSIG; s++) begin
            if (sig_link[s].valid) begin
                nlinked++;
                AST_PIN_ORDER: assert (int'(sig_link[s].idx) > last) else $error("pin order broken"); // R1
                last = int'(sig_link[s].idx);
            end
        end
        AST_NO_OVERFLOW: assert (overflow || nlinked == $countones(active)) else $error("active signal lost"); // R5
        AST_OVF_DROPS: assert (!overflow || nlinked < $countones(active)) else $error("overflow without drop"); // R5
        for (int p = 0; p < NPIN; p++) begin
            if (pin_skip[p]) begin
                AST_SKIP_GPIO: assert (pad_out[p] == (pin_push_pull[p] & latch_out[p]) &&
                                       pad_oe[p] == (pin_push_pull[p] | ~latch_out[p]))
                    else $error("skipped pin not GPIO"); // R4
            end
        end
    end

endmodule

// File: tb/tb_pin_xbar.sv
module tb_pin_xbar;
    import xbar_pkg::*;

    localparam int NPIN = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NFUNC-1:0] func_en;
    logic [2:0]       pca_width;
    logic [NPIN-1:0]  pin_skip;
    logic [NSIG-1:0]  periph_out, periph_oe, periph_in;
    logic [NPIN-1:0]  latch_out, pin_push_pull, pad_in;
    logic [NPIN-1:0]  pad_out, pad_oe, latch_rd;
    logic             overflow;

    pin_xbar #(.NPIN(NPIN)) dut (
        .func_en(func_en), .pca_width(pca_width), .pin_skip(pin_skip),
        .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
        .latch_out(latch_out), .pin_push_pull(pin_push_pull), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .latch_rd(latch_rd), .overflow(overflow)
    );

    int checks = 0;
    int fails  = 0;
    int exp_pin [NSIG];
    logic exp_ovf;

    function automatic int width_of(input int f, input int pw);
        int w [NFUNC] = '{2, 4, 2, 2, 2, 1, 7, 4, 2};
        return (f == 6) ? pw : w[f];
    endfunction

    // Reference packing: list of free pins, functions placed whole in priority order
    task automatic ref_model();
        int freel [NPIN];
        int nfree, used, total, base;
        bit ok;
        int w [NFUNC] = '{2, 4, 2, 2, 2, 1, 7, 4, 2};
        nfree = 0;
        for (int p = 0; p < NPIN; p++) if (!pin_skip[p]) begin freel[nfree] = p; nfree++; end
        for (int s = 0; s < NSIG; s++) exp_pin[s] = -1;
        used = 0; total = 0; base = 0; ok = 1;
        for (int f = 0; f < NFUNC; f++) begin
            if (func_en[f]) begin
                int n;
                n = width_of(f, int'(pca_width));
                total += n;
                if (ok && used + n <= nfree) begin
                    for (int k = 0; k < n; k++) exp_pin[base + k] = freel[used + k];
                    used += n;
                end else ok = 0;
            end
            base += w[f];
        end
        exp_ovf = (total > nfree);
    endtask

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply_and_check(input string tag);
        logic [NPIN-1:0] e_out, e_oe;
        logic [NSIG-1:0] e_in;
        @(posedge clk);
        #1;
        ref_model();
        for (int p = 0; p < NPIN; p++) begin
            logic v, r;
            v = latch_out[p]; r = 1'b1;
            for (int s = 0; s < NSIG; s++) if (exp_pin[s] == p) begin v = periph_out[s]; r = periph_oe[s]; end
            e_out[p] = pin_push_pull[p] ? v : 1'b0;
            e_oe[p]  = r & (pin_push_pull[p] | ~v);
        end
        for (int s = 0; s < NSIG; s++) e_in[s] = (exp_pin[s] >= 0) ? pad_in[exp_pin[s]] : 1'b1;
        @(negedge clk);
        check({"R5 ", tag}, "overflow", 64'(overflow), 64'(exp_ovf));
        check({"R1 R2 R3 R4 R6 R7 R8 ", tag}, "pad_out", 64'(pad_out), 64'(e_out));
        check({"R6 R7 R8 ", tag}, "pad_oe", 64'(pad_oe), 64'(e_oe));
        check({"R10 ", tag}, "periph_in", 64'(periph_in), 64'(e_in));
        check({"R9 ", tag}, "latch_rd", 64'(latch_rd), 64'(pad_in));
    endtask

    task automatic rand_data();
        periph_out    = NSIG'({$urandom, $urandom});
        periph_oe     = NSIG'({$urandom, $urandom});
        latch_out     = NPIN'($urandom);
        pin_push_pull = NPIN'($urandom);
        pad_in        = NPIN'($urandom);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(1234);
        func_en = '0; pca_width = '0; pin_skip = '0;
        periph_out = '0; periph_oe = '0; latch_out = '0;
        pin_push_pull = '1; pad_in = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset-like idle: nothing enabled, all GPIO (R7)
        rand_data();
        apply_and_check("idle");
        // UART only lands on pins 0,1 (R1 R2)
        func_en = 9'b000000001; rand_data();
        apply_and_check("uart");
        // Skip pin 0 shifts UART to pins 1,2 (R4)
        pin_skip = 25'h1; apply_and_check("skip0");
        // Clock output alone takes one pin (R2)
        pin_skip = '0; func_en = 9'b000100000; apply_and_check("clko");
        // PCA width 0 and 7 (R3)
        func_en = 9'b001000000; pca_width = 3'd0; apply_and_check("pca0");
        pca_width = 3'd7; apply_and_check("pca7");
        // All enabled, 26 signals on 25 pins: LIN dropped, overflow (R5)
        func_en = '1; rand_data(); apply_and_check("full");
        // All enabled, PCA 6: exactly fits
        pca_width = 3'd6; apply_and_check("exact");
        // Skipping a pin with exact fit drops LIN (R4 R5)
        pin_skip = 25'h1000; apply_and_check("skipmid");
        // All pins skipped, everything dropped
        pin_skip = '1; apply_and_check("allskip");
        // Open-drain everywhere (R8)
        pin_skip = '0; func_en = 9'b000001111; pin_push_pull = '0; apply_and_check("od");

        for (int i = 0; i < 400; i++) begin
            func_en   = NFUNC'($urandom);
            pca_width = 3'($urandom);
            pin_skip  = NPIN'($urandom) & NPIN'($urandom);
            rand_data();
            apply_and_check("random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule